// File: doc/BRIEF.md
# Shared Interrupt Router

This block takes a set of shared external interrupt lines and forwards each one to the interrupt inputs of several cores. Every shared line has its own configuration: a destination core set, a distribution scheme and a mask bit. The unit as a whole starts disabled and forwards nothing until software enables it.

Configuration arrives over a one-cycle command port carrying an opcode, a line index and a data word. A line can be steered to a single fixed core, the lowest-numbered core in its destination set, or it can be spread over the destination set round-robin. In round-robin mode each fresh assertion moves to the next core after the one used last, and that core keeps the line for as long as the request stays high. Shared line `i` appears on interrupt input `LINE_BASE + i` of every core (24 + i by default), so each core sees a wide interrupt vector in which only the shared window is driven by this block.

All routed outputs are registered. An output reflects the inputs and configuration sampled at the previous clock edge.

Top module: `shared_irq_router`

## Requirements
- R1: After reset every output is low, every line is masked, every destination set is empty and the unit is disabled; enabling the unit and setting a destination alone forwards nothing until the line is unmasked.
- R2: While the unit has not been enabled (opcode 4), no line drives any core output.
- R3: Opcode 1 writes the destination set of line `cmd_idx`; data bit c selects core c, and no core outside the set is ever driven.
- R4: Opcode 2 writes the mode of line `cmd_idx`: data bits [1:0] equal to 0 select round-robin, any other value selects fixed destination; data bit 4 (level trigger) is accepted and does not change routing.
- R5: In fixed mode the line drives only the lowest-numbered core present in its destination set.
- R6: Opcode 3 with data bit 0 set masks line `cmd_idx`, with bit 0 clear unmasks it; a masked line drives no core output.
- R7: In round-robin mode each new assertion of a line goes to the next core in its destination set after the core last used, wrapping from the highest core to the lowest; after reset the first pick is the lowest core in the set.
- R8: In round-robin mode the chosen core keeps receiving the line for every cycle the request stays high.
- R9: A line with an empty destination set drives no core output even when unmasked and enabled.
- R10: Line i drives bit LINE_BASE+i of each core's vector; every other bit of every core's vector stays low.
- R11: A change on an input line becomes visible on the outputs one clock cycle later.
- R12: At any time a line drives at most one core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode: 1 destination, 2 mode, 3 mask, 4 enable |
| cmd_idx | input | IDX_W (3) | Shared line index |
| cmd_data | input | DATA_W (32) | Command data word |
| irq_in | input | N_SRC (8) | Shared interrupt request lines, level sensitive |
| core_irq | output | N_CORE*LINE_W (128) | Per-core interrupt vectors, core c in bits [c*LINE_W +: LINE_W] |

## Verification
The bench goes after the round-robin rotation: starting from reset it expects the first pick to be the lowest core of a sparse set, then the following set members in order, then a wrap, so a design that rotated over all cores instead of the set, or forgot the last-used core, would land on the wrong line. It holds a request high for several cycles to catch a design that re-picks every cycle and so sprays one interrupt across cores. It checks the gating order at reset (masked by default, disabled until enabled) and an empty destination set, where a design that defaulted to core 0 would fire spuriously. It also probes the one-cycle latency and the line offset, where an off-by-one lands the interrupt on a neighbouring vector bit.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_DEST   = 3'd1,
      OP_MODE   = 3'd2,
      OP_MASK   = 3'd3,
      OP_ENABLE = 3'd4
   } shirq_op_e;

   localparam logic [1:0] SCHEME_ROUND_ROBIN = 2'd0;

endpackage

// File: rtl/shirq_cfg_bank.sv
module shirq_cfg_bank
   import shirq_pkg::*;
#(
   parameter int N_SRC  = 8,
   parameter int N_CORE = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic [2:0]              cmd_op,
   input  logic [IDX_W-1:0]        cmd_idx,
   input  logic [DATA_W-1:0]       cmd_data,
   output logic                    unit_en,
   output logic [N_SRC-1:0]        line_mask,
   output logic [N_SRC-1:0]        line_rr,
   output logic [N_SRC*N_CORE-1:0] line_dest
);

   logic unused_data;
   assign unused_data = ^cmd_data;

   logic idx_ok;
   assign idx_ok = (int'(cmd_idx) < N_SRC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unit_en <= 1'b0;
      end else if (cmd_valid && shirq_op_e'(cmd_op) == OP_ENABLE) begin
         unit_en <= 1'b1;
      end
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_line
      logic hit;
      assign hit = cmd_valid && idx_ok && (int'(cmd_idx) == s);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            line_mask[s]                   <= 1'b1;
            line_rr[s]                     <= 1'b0;
            line_dest[s*N_CORE +: N_CORE]  <= '0;
         end else if (hit) begin
            unique case (shirq_op_e'(cmd_op))
               OP_DEST: line_dest[s*N_CORE +: N_CORE] <= cmd_data[N_CORE-1:0];
               OP_MODE: line_rr[s]   <= (cmd_data[1:0] == SCHEME_ROUND_ROBIN);
               OP_MASK: line_mask[s] <= cmd_data[0];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/shirq_lane.sv
module shirq_lane #(
   parameter int N_CORE = 4,
   localparam int CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src,
   input  logic              en,
   input  logic              masked,
   input  logic              rr_mode,
   input  logic [N_CORE-1:0] dest,
   output logic [N_CORE-1:0] target_q
);

   logic              req, req_q, rise, need_pick;
   logic [CW-1:0]     last_q, next_idx;
   logic [N_CORE-1:0] held_q, rr_next, fix_pick, pick;

   assign req  = src & en & ~masked & (|dest);
   assign rise = req & ~req_q;
   assign need_pick = rr_mode & req & (rise | ~|(held_q & dest));

   always_comb begin
      logic found;
      rr_next  = '0;
      next_idx = last_q;
      found    = 1'b0;
      for (int k = 1; k <= N_CORE; k++) begin
         int j;
         j = (int'(last_q) + k) % N_CORE;
         if (!found && dest[j]) begin
            rr_next[j] = 1'b1;
            next_idx   = CW'(j);
            found      = 1'b1;
         end
      end
   end

   always_comb begin
      fix_pick = '0;
      for (int k = N_CORE - 1; k >= 0; k--) begin
         if (dest[k]) begin
            fix_pick    = '0;
            fix_pick[k] = 1'b1;
         end
      end
   end

   always_comb begin
      if (!req)          pick = '0;
      else if (!rr_mode) pick = fix_pick;
      else if (need_pick) pick = rr_next;
      else               pick = held_q & dest;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q    <= 1'b0;
         held_q   <= '0;
         last_q   <= CW'(N_CORE - 1);
         target_q <= '0;
      end else begin
         req_q    <= req;
         target_q <= pick;
         if (need_pick) begin
            held_q <= rr_next;
            last_q <= next_idx;
         end
      end
   end

   assert_one_core_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(target_q));

   assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      masked |=> (target_q == '0));

   assert_disabled_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (target_q == '0));

   assert_empty_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dest == '0) |=> (target_q == '0));

   assert_inside_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((target_q & ~$past(dest)) == '0));

endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router
   import shirq_pkg::*;
#(
   parameter int N_SRC     = 8,
   parameter int N_CORE    = 4,
   parameter int DATA_W    = 32,
   parameter int LINE_W    = 32,
   parameter int LINE_BASE = 24,
   localparam int IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic [2:0]               cmd_op,
   input  logic [IDX_W-1:0]         cmd_idx,
   input  logic [DATA_W-1:0]        cmd_data,
   input  logic [N_SRC-1:0]         irq_in,
   output logic [N_CORE*LINE_W-1:0] core_irq
);

   if (N_SRC < 1 || N_CORE < 1) begin : g_bad_count
      $error("shared_irq_router: N_SRC and N_CORE must be at least 1");
   end
   if (LINE_BASE + N_SRC > LINE_W) begin : g_bad_window
      $error("shared_irq_router: shared window exceeds core vector width");
   end
   if (DATA_W < 5 || N_CORE > DATA_W) begin : g_bad_data
      $error("shared_irq_router: data word too narrow");
   end

   logic                    unit_en;
   logic [N_SRC-1:0]        line_mask, line_rr;
   logic [N_SRC*N_CORE-1:0] line_dest;

   shirq_cfg_bank #(
      .N_SRC (N_SRC),
      .N_CORE(N_CORE),
      .DATA_W(DATA_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .cmd_idx  (cmd_idx),
      .cmd_data (cmd_data),
      .unit_en  (unit_en),
      .line_mask(line_mask),
      .line_rr  (line_rr),
      .line_dest(line_dest)
   );

   logic [N_SRC*N_CORE-1:0] lane_tgt;

   for (genvar s = 0; s < N_SRC; s++) begin : g_lane
      shirq_lane #(.N_CORE(N_CORE)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .src     (irq_in[s]),
         .en      (unit_en),
         .masked  (line_mask[s]),
         .rr_mode (line_rr[s]),
         .dest    (line_dest[s*N_CORE +: N_CORE]),
         .target_q(lane_tgt[s*N_CORE +: N_CORE])
      );
   end

   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      for (genvar b = 0; b < LINE_W; b++) begin : g_bit
         if (b >= LINE_BASE && b < LINE_BASE + N_SRC) begin : g_shared
            assign core_irq[c*LINE_W + b] = lane_tgt[(b - LINE_BASE)*N_CORE + c];
         end else begin : g_idle
            assign core_irq[c*LINE_W + b] = 1'b0;
         end
      end
   end

endmodule

// File: tb/shared_irq_router_test.sv
module shared_irq_router_test;

   localparam int NS = 8, NC = 4, DW = 32, LW = 32, LB = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [2:0]    cmd_idx = '0;
   logic [DW-1:0] cmd_data = '0;
   logic [NS-1:0] irq_in = '0;
   logic [NC*LW-1:0] core_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   shared_irq_router uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_in(irq_in), .core_irq(core_irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic cmd(input logic [2:0] op, input int idx, input logic [DW-1:0] d);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = 3'(idx); cmd_data = d;
      step();
      cmd_valid = 1'b0; cmd_op = '0;
   endtask

   function automatic logic [NC-1:0] cores_of(input int s);
      logic [NC-1:0] r;
      for (int c = 0; c < NC; c++) r[c] = core_irq[c*LW + LB + s];
      return r;
   endfunction

   task automatic chk_line(input string req, input int s, input logic [NC-1:0] exp);
      checks++;
      if (cores_of(s) !== exp) begin
         errors++;
         $display("FAIL %s line %0d: cores=%b expected=%b", req, s, cores_of(s), exp);
      end
   endtask

   task automatic chk_all_zero(input string req);
      checks++;
      if (core_irq !== '0) begin
         errors++;
         $display("FAIL %s: core_irq=%h expected=0", req, core_irq);
      end
   endtask

   task automatic t_reset();
      chk_all_zero("R1 reset outputs");
      irq_in = '1;
      for (int s = 0; s < NS; s++) begin
         cmd(3'd1, s, 32'hF);
         cmd(3'd2, s, 32'h11);
      end
      cmd(3'd4, 0, 32'h0);
      step();
      chk_all_zero("R1 masked by default");
      irq_in = '0;
      step();
   endtask

   task automatic t_enable_gate();
      // reset again, unmask everything but do not enable
      rst_n = 1'b0; step(); rst_n = 1'b1; step();
      irq_in = '1;
      for (int s = 0; s < NS; s++) begin
         cmd(3'd1, s, 32'hF);
         cmd(3'd2, s, 32'h13);
         cmd(3'd3, s, 32'h0);
      end
      step();
      chk_all_zero("R2 disabled unit");
      cmd(3'd4, 0, 32'h0);
      step();
      for (int s = 0; s < NS; s++) chk_line("R10 R5 enable lowest core", s, 4'b0001);
      begin
         logic [NC*LW-1:0] win;
         win = '0;
         for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++) win[c*LW + LB + s] = 1'b1;
         checks++;
         if ((core_irq & ~win) !== '0) begin
            errors++;
            $display("FAIL R10 lines outside window: %h expected=0", core_irq & ~win);
         end
      end
      irq_in = '0;
      step();
   endtask

   task automatic t_fixed();
      irq_in[0] = 1'b1;
      cmd(3'd1, 0, 32'hA);
      step();
      chk_line("R5 fixed lowest of 1010", 0, 4'b0010);
      cmd(3'd1, 0, 32'h8);
      step();
      chk_line("R3 dest bit3 only", 0, 4'b1000);
      cmd(3'd1, 0, 32'h0);
      step();
      chk_line("R9 empty dest", 0, 4'b0000);
      cmd(3'd1, 0, 32'h6);
      step();
      chk_line("R5 fixed lowest of 0110", 0, 4'b0010);
      cmd(3'd3, 0, 32'h1);
      step();
      chk_line("R6 masked line", 0, 4'b0000);
      cmd(3'd3, 0, 32'h0);
      step();
      chk_line("R6 unmasked again", 0, 4'b0010);
      irq_in[0] = 1'b0;
      step();
      chk_line("R11 drop", 0, 4'b0000);
   endtask

   task automatic t_rr();
      logic [NC-1:0] seq [4];
      seq[0] = 4'b0001; seq[1] = 4'b0010; seq[2] = 4'b1000; seq[3] = 4'b0001;
      irq_in = '0;
      rst_n = 1'b0; step(); rst_n = 1'b1; step();
      cmd(3'd4, 0, 32'h0);
      cmd(3'd1, 2, 32'hB);
      cmd(3'd2, 2, 32'h10);
      cmd(3'd3, 2, 32'h0);
      step();
      for (int p = 0; p < 4; p++) begin
         irq_in[2] = 1'b1;
         if (p == 0) chk_line("R11 not yet visible", 2, 4'b0000);
         step();
         chk_line("R7 round-robin pick", 2, seq[p]);
         for (int h = 0; h < 3; h++) begin
            step();
            chk_line("R8 pick held", 2, seq[p]);
         end
         irq_in[2] = 1'b0;
         step();
         chk_line("R11 release", 2, 4'b0000);
         step();
      end
      // mode bits 01 with trigger bit set select fixed again
      cmd(3'd2, 2, 32'h11);
      irq_in[2] = 1'b1;
      step();
      chk_line("R4 fixed after mode write", 2, 4'b0001);
      irq_in[2] = 1'b0;
      step();
   endtask

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_enable_gate();
      t_fixed();
      t_rr();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule